// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Match Scheduler

This block chooses, once per cell time, which inputs of an N-port input-queued crossbar connect to which outputs. Each input keeps a separate queue per output. A request matrix reports which of those queues hold a cell, and the block returns a conflict-free pairing in which every input and every output is used at most once.

The pairing is built over several request/grant/accept rounds, one round per clock. In each round, every output that is still free grants one free input that requests it. Every input that receives grants then accepts one of them. Both choices come from round-robin arbiters, each driven by a stored pointer.

Pointers change only for pairs formed in the first round, and a grant pointer moves only when its grant is taken. Under load, the arbiters therefore drift apart and settle into rotating service. The cell time ends after the configured number of rounds, or sooner if a round adds no pair.

Top module: `rr_xbar_sched`

## Requirements
- R1: After reset, busy, done and match-valid are low, the match output is zero, and every grant and accept pointer is 0. The first cell with all requests set therefore pairs input k with output k.
- R2: A start pulse while idle latches req_i and raises busy on the next cycle. One round then runs per clock. A start pulse while busy is ignored, along with the request value present at that time.
- R3: In the match output, each input row and each output column has at most one bit set.
- R4: Every bit set in the match output was set in the request matrix latched at start.
- R5: Only outputs and inputs still free take part in a round. Each such output grants the first requesting free input found from its grant pointer upward, wrapping modulo N.
- R6: An input holding grants accepts the first granting output found from its accept pointer upward, wrapping modulo N.
- R7: A grant pointer becomes one past the granted input (modulo N) only when that grant is accepted in the first round. Rejected grants and pairs formed in later rounds leave it unchanged.
- R8: An accept pointer becomes one past the accepted output (modulo N) only for pairs formed in the first round.
- R9: done pulses for one cycle right after the round that added no pair, or after round MAX_ITER, whichever comes first. Latency is counted in clocks from the edge that took start.
- R10: match_o bit i*N+j set means input i is paired with output j. It is zero while match_valid_o is low. match_valid_o rises with done and then holds, together with an unchanged match, until the next accepted start.
- R11: When done arrives before round MAX_ITER, the match is maximal: no requested pair has both its input and its output unpaired.
- R12: An input that requests the same output in every cell time is paired with it within N*N cell times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a cell time when idle |
| req_i | input | N*N | Request matrix, bit i*N+j: input i has a cell for output j |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse when the match is final |
| match_valid_o | output | 1 | match_o holds the final match |
| match_o | output | N*N | Match matrix, bit i*N+j: input i paired with output j |

## Verification
The assertions watch, on every cycle, the properties that do not depend on history: row and column exclusivity of the match, its containment in the latched requests, the one-cycle done pulse, the holding of the match while valid, and pointers staying still outside the first round. Which input an arbiter picks, where its pointer lands, how pointers drift apart over consecutive full-load cells, and the latency of early convergence are shown only by the bench's directed scenarios. Those scenarios use hand-derived match matrices. Maximality on early exit and the bound on starvation are also shown only by the bench, across a pseudo-random request stream and a long run under sustained contention.

// File: rtl/rr_xbar_pkg.sv
package rr_xbar_pkg;
    // next position after idx on a ring of n slots
    function automatic int unsigned rr_wrap_next(int unsigned idx, int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N = 4,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] ptr,
    output logic [N-1:0] pick,
    output logic [W-1:0] idx,
    output logic         any
);
    always_comb begin
        int unsigned p;
        pick = '0;
        idx  = '0;
        any  = 1'b0;
        p    = 0;
        for (int k = 0; k < N; k++) begin
            p = 32'(ptr) + 32'(k);
            if (p >= 32'(N)) p = p - 32'(N);
            if (req[p] && !any) begin
                pick[p] = 1'b1;
                idx     = W'(p);
                any     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rr_match_stage.sv
module rr_match_stage #(
    parameter int N = 4,
    parameter int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*N-1:0] req,
    input  logic [N-1:0]   in_free,
    input  logic [N-1:0]   out_free,
    input  logic [N*W-1:0] gptr,
    input  logic [N*W-1:0] aptr,
    output logic [N*N-1:0] acc,
    output logic [N-1:0]   in_hit,
    output logic [N*W-1:0] in_sel,
    output logic [N-1:0]   out_hit,
    output logic [N*W-1:0] out_sel
);
    logic [N-1:0] col_req [N];
    logic [N-1:0] gnt_out [N];
    logic [N-1:0] gnt_in  [N];
    logic [N-1:0] acc_in  [N];
    logic [W-1:0] g_idx   [N];
    logic [N-1:0] g_any;

    always_comb begin
        for (int j = 0; j < N; j++)
            for (int i = 0; i < N; i++)
                col_req[j][i] = req[i*N+j] & in_free[i] & out_free[j];
    end

    for (genvar j = 0; j < N; j++) begin : g_grant
        rr_pick #(.N(N), .W(W)) u_garb (
            .req (col_req[j]),
            .ptr (gptr[j*W +: W]),
            .pick(gnt_out[j]),
            .idx (g_idx[j]),
            .any (g_any[j])
        );
        assign out_sel[j*W +: W] = g_idx[j];
    end

    always_comb begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                gnt_in[i][j] = gnt_out[j][i];
    end

    for (genvar i = 0; i < N; i++) begin : g_accept
        rr_pick #(.N(N), .W(W)) u_aarb (
            .req (gnt_in[i]),
            .ptr (aptr[i*W +: W]),
            .pick(acc_in[i]),
            .idx (in_sel[i*W +: W]),
            .any (in_hit[i])
        );
    end

    always_comb begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                acc[i*N+j] = acc_in[i][j];
        for (int j = 0; j < N; j++)
            out_hit[j] = g_any[j] & acc_in[g_idx[j]][j];
    end
endmodule

// File: rtl/rr_xbar_sched.sv
module rr_xbar_sched
    import rr_xbar_pkg::*;
#(
    parameter int N        = 4,
    parameter int MAX_ITER = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N*N-1:0] req_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           match_valid_o,
    output logic [N*N-1:0] match_o
);
    localparam int W  = (N > 1) ? $clog2(N) : 1;
    localparam int IW = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;

    typedef struct packed {
        logic           busy;
        logic           done;
        logic           valid;
        logic [IW-1:0]  iter;
        logic [N*N-1:0] req;
        logic [N*N-1:0] match;
        logic [N-1:0]   in_used;
        logic [N-1:0]   out_used;
        logic [N*W-1:0] gptr;
        logic [N*W-1:0] aptr;
    } sched_st_t;

    sched_st_t st_d, st_q;

    logic [N*N-1:0] acc_new;
    logic [N-1:0]   in_hit, out_hit;
    logic [N*W-1:0] in_sel, out_sel;

    // signals exposed for the bound checker
    logic [N*N-1:0] req_lat;
    logic [N*W-1:0] gptr_cur, aptr_cur;
    logic [IW-1:0]  iter_cur;

    rr_match_stage #(.N(N), .W(W)) u_stage (
        .req     (st_q.req),
        .in_free (~st_q.in_used),
        .out_free(~st_q.out_used),
        .gptr    (st_q.gptr),
        .aptr    (st_q.aptr),
        .acc     (acc_new),
        .in_hit  (in_hit),
        .in_sel  (in_sel),
        .out_hit (out_hit),
        .out_sel (out_sel)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy     = 1'b1;
                st_d.valid    = 1'b0;
                st_d.req      = req_i;
                st_d.match    = '0;
                st_d.in_used  = '0;
                st_d.out_used = '0;
                st_d.iter     = '0;
            end
        end else begin
            st_d.match    = st_q.match | acc_new;
            st_d.in_used  = st_q.in_used | in_hit;
            st_d.out_used = st_q.out_used | out_hit;
            if (st_q.iter == '0) begin
                for (int i = 0; i < N; i++)
                    if (in_hit[i])
                        st_d.aptr[i*W +: W] = W'(rr_wrap_next(32'(in_sel[i*W +: W]), N));
                for (int j = 0; j < N; j++)
                    if (out_hit[j])
                        st_d.gptr[j*W +: W] = W'(rr_wrap_next(32'(out_sel[j*W +: W]), N));
            end
            if (in_hit == '0 || st_q.iter == IW'(MAX_ITER - 1)) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.valid = 1'b1;
            end else begin
                st_d.iter = st_q.iter + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o        = st_q.busy;
    assign done_o        = st_q.done;
    assign match_valid_o = st_q.valid;
    assign match_o       = st_q.valid ? st_q.match : '0;
    assign req_lat       = st_q.req;
    assign gptr_cur      = st_q.gptr;
    assign aptr_cur      = st_q.aptr;
    assign iter_cur      = st_q.iter;
endmodule

// File: rtl/rr_xbar_sched_chk.sv
module rr_xbar_sched_chk #(
    parameter int N        = 4,
    parameter int MAX_ITER = 4,
    parameter int W        = (N > 1) ? $clog2(N) : 1,
    parameter int IW       = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           busy_o,
    input logic           done_o,
    input logic           match_valid_o,
    input logic [N*N-1:0] match_o,
    input logic [N*N-1:0] req_lat,
    input logic [N*W-1:0] gptr_cur,
    input logic [N*W-1:0] aptr_cur,
    input logic [IW-1:0]  iter_cur
);
    logic [N-1:0] col [N];
    always_comb begin
        for (int j = 0; j < N; j++)
            for (int i = 0; i < N; i++)
                col[j][i] = match_o[i*N+j];
    end

    for (genvar k = 0; k < N; k++) begin : g_excl
        a_r3_row_excl: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(match_o[k*N +: N]));
        a_r3_col_excl: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col[k]));
    end

    a_r4_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o & ~req_lat) == '0);

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

    a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_valid_o) |-> done_o);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (match_valid_o && !start_i) |=> (match_valid_o && $stable(match_o)));

    a_r7_gptr_first_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o || iter_cur != '0) |=> $stable(gptr_cur));

    a_r8_aptr_first_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o || iter_cur != '0) |=> $stable(aptr_cur));
endmodule

bind rr_xbar_sched rr_xbar_sched_chk #(.N(N), .MAX_ITER(MAX_ITER)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .match_valid_o(match_valid_o),
    .match_o      (match_o),
    .req_lat      (req_lat),
    .gptr_cur     (gptr_cur),
    .aptr_cur     (aptr_cur),
    .iter_cur     (iter_cur)
);

// File: tb/tb_rr_xbar_sched.sv
module tb_rr_xbar_sched;
    localparam int N = 4;
    localparam int MI = 4;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [N*N-1:0] req_i = '0;
    logic          busy_o, done_o, match_valid_o;
    logic [N*N-1:0] match_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    rr_xbar_sched #(.N(N), .MAX_ITER(MI)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_i(req_i),
        .busy_o(busy_o), .done_o(done_o), .match_valid_o(match_valid_o), .match_o(match_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual cycles=%0d expected<=100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit conflict_free(input logic [N*N-1:0] m);
        for (int k = 0; k < N; k++) begin
            int r = 0; int c = 0;
            for (int t = 0; t < N; t++) begin
                r += int'(m[k*N+t]); c += int'(m[t*N+k]);
            end
            if (r > 1 || c > 1) return 0;
        end
        return 1;
    endfunction

    function automatic bit maximal(input logic [N*N-1:0] m, input logic [N*N-1:0] r);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (r[i*N+j]) begin
                    bit ri = 0; bit cj = 0;
                    for (int t = 0; t < N; t++) begin
                        ri |= m[i*N+t]; cj |= m[t*N+j];
                    end
                    if (!ri && !cj) return 0;
                end
        return 1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_i = 1'b0; req_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // runs one cell; returns at a negedge with done sampled high
    task automatic run_cell(input logic [N*N-1:0] r, output logic [N*N-1:0] m, output int lat);
        req_i = r; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        do begin
            @(posedge clk); lat++;
            @(negedge clk);
        end while (!done_o && lat < 20);
        m = match_o;
        check(match_valid_o === 1'b1, "R10 valid at done", 32'(match_valid_o), 32'd1);
    endtask

    task automatic t_reset();
        do_reset();
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 busy/done after reset", {busy_o, done_o}, 0);
        check(match_valid_o === 1'b0, "R1 valid after reset", 32'(match_valid_o), 0);
        check(match_o === '0, "R1 match after reset", 32'(match_o), 0);
    endtask

    task automatic t_full_load();
        logic [N*N-1:0] m; int lat;
        do_reset();
        run_cell('1, m, lat);
        check(m === 16'h8421, "R1 R5 R6 first full cell", 32'(m), 32'h8421);
        check(lat == 4, "R9 MAX_ITER latency", lat, 4);
        run_cell('1, m, lat);
        check(m === 16'h8412, "R7 R8 second full cell", 32'(m), 32'h8412);
        run_cell('1, m, lat);
        check(m === 16'h8124, "R7 R8 third full cell", 32'(m), 32'h8124);
        check(lat == 3, "R9 early convergence latency", lat, 3);
    endtask

    task automatic t_reject();
        logic [N*N-1:0] m; int lat;
        do_reset();
        run_cell(16'h0023, m, lat);
        check(m === 16'h0021, "R5 R6 reject cell1", 32'(m), 32'h0021);
        check(lat == 3, "R9 reject cell1 latency", lat, 3);
        run_cell(16'h0023, m, lat);
        check(m === 16'h0002, "R7 R8 reject cell2", 32'(m), 32'h0002);
        check(lat == 2, "R9 reject cell2 latency", lat, 2);
        run_cell(16'h0023, m, lat);
        check(m === 16'h0021, "R7 R8 reject cell3", 32'(m), 32'h0021);
    endtask

    task automatic t_single_empty();
        logic [N*N-1:0] m; int lat;
        do_reset();
        run_cell(16'h0800, m, lat);
        check(m === 16'h0800, "R4 single request", 32'(m), 32'h0800);
        check(lat == 2, "R9 single latency", lat, 2);
        run_cell('0, m, lat);
        check(m === '0, "R4 empty request", 32'(m), 0);
        check(lat == 1, "R9 empty latency", lat, 1);
    endtask

    task automatic t_valid_hold();
        logic [N*N-1:0] m; int lat;
        do_reset();
        run_cell(16'h0800, m, lat);
        repeat (3) @(negedge clk);
        check(match_valid_o === 1'b1 && match_o === 16'h0800, "R10 hold", 32'(match_o), 32'h0800);
        req_i = '1; start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        check(match_valid_o === 1'b0 && match_o === '0 && busy_o === 1'b1, "R10 R2 cleared on start",
              {busy_o, match_valid_o, 14'(match_o)}, 32'h8000);
        while (!done_o) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        int lat;
        do_reset();
        req_i = '1; start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        req_i = '0;           // start stays high while busy
        lat = 0;
        repeat (2) begin @(posedge clk); lat++; @(negedge clk); end
        start_i = 1'b0;
        while (!done_o && lat < 20) begin @(posedge clk); lat++; @(negedge clk); end
        check(match_o === 16'h8421, "R2 start while busy ignored", 32'(match_o), 32'h8421);
        check(lat == 4, "R2 one round per clock", lat, 4);
    endtask

    task automatic t_random();
        logic [15:0] lf = 16'hACE1;
        logic [N*N-1:0] m; int lat;
        do_reset();
        for (int c = 0; c < 60; c++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run_cell(lf, m, lat);
            check(conflict_free(m), "R3 conflict free", 32'(m), 0);
            check((m & ~lf) == '0, "R4 subset of requests", 32'(m & ~lf), 0);
            if (lat < MI) check(maximal(m, lf), "R11 maximal on early exit", 32'(m), 32'(lf));
        end
    endtask

    task automatic t_starve();
        logic [N*N-1:0] m; int lat; int served_at;
        do_reset();
        served_at = -1;
        for (int c = 0; c < N*N; c++) begin
            run_cell(16'h1FFF, m, lat);
            if (m[12] && served_at < 0) served_at = c;
        end
        check(served_at >= 0, "R12 served within N*N cells", served_at, 0);
    endtask

    initial begin
        t_reset();
        t_full_load();
        t_reject();
        t_single_empty();
        t_valid_hold();
        t_busy_ignore();
        t_random();
        t_starve();
        summary();
        $finish;
    end
endmodule